// File: doc/BRIEF.md
# Instruction Fetch Trace Decoder

This block observes a processor's active-low fetch indication together with its address and data strobes and classifies each bus cycle as a plain prefetch, a pipeline flush with a prefetch, or no fetch. The fetch pin carries two meanings by pulse width. One clock low marks a prefetch and two clocks low mark a flush. The decoder therefore takes exactly two samples of the pin per bus cycle. The first is taken on the clock edge where the reference strobe is first seen low after being high, and the second on the edge after that. The reference strobe is the address strobe, or the data strobe while a show cycle is flagged.

Because each window is tied to a strobe, a fast two-clock bus can keep the pin low for three clocks in a row and still decode correctly: the first two samples give a flush and the third opens the next cycle's window as a fresh fetch. On slower buses the pin always returns high between indications. In that mode a low level that merely continues from the previous clock is not taken as a new indication at the start of a window.

Alongside the pulses, the block keeps an occupancy count for a three-word prefetch queue model. Fetches fill the count, consumed words drain it, and a flush resets it to the single refill word.

Top module: `fetch_trace_decoder`

## Requirements
- R1: While rst is high and on the first cycle after it, fetch_pulse and flush_pulse are 0 and occupancy is 0.
- R2: A window opens on the clock edge where the reference strobe is sampled low after being sampled high on the previous edge. fetch_n is sampled on that edge and on the next one. The outcome appears as a one-cycle pulse after the edge that follows the second sample, and never earlier.
- R3: Exactly one of the two samples low (fetch_n = 0) yields fetch_pulse = 1 for one cycle and flush_pulse = 0.
- R4: Both samples low yields flush_pulse = 1 for one cycle and fetch_pulse = 0.
- R5: Both samples high yields no pulse and leaves occupancy unchanged.
- R6: With show_cycle = 1 the reference strobe is ds_n and as_n is ignored. With show_cycle = 0 the reference is as_n and ds_n is ignored.
- R7: With two_clk_mode = 1, a low run of three edges spanning two back-to-back bus cycles gives a flush_pulse for the first cycle and then a fetch_pulse for the second.
- R8: With two_clk_mode = 0, a first window sample that is low and continues a low level from the previous edge counts as high.
- R9: A flush sets occupancy to 1, whether or not consume is high on the same edge.
- R10: A fetch without consume increments occupancy, saturating at QDEPTH (3 by default).
- R11: A consume pulse without a fetch decrements occupancy, stopping at 0. A fetch and a consume on the same edge leave occupancy unchanged.
- R12: fetch_pulse and flush_pulse are never high together, and no pulse is ever followed by another pulse on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_n | input | 1 | Active-low fetch indication pin |
| as_n | input | 1 | Active-low address strobe |
| ds_n | input | 1 | Active-low data strobe |
| show_cycle | input | 1 | 1 selects ds_n as the reference strobe |
| two_clk_mode | input | 1 | 1 for a two-clock bus, 0 for three-clock or slower |
| consume | input | 1 | One pulse per word taken from the queue model |
| fetch_pulse | output | 1 | One-cycle pulse for a plain prefetch |
| flush_pulse | output | 1 | One-cycle pulse for a flush with prefetch |
| occupancy | output | $clog2(QDEPTH+1) | Queue model word count |

## Verification
Call the edge that sees the strobe fall E0. The pulses and the matching occupancy update become visible after edge E2, two edges later. Consume counts on the edge where it is high, so its effect shows right after that edge. The bench drives every input on falling clock edges. Each pulse is checked at three points: after E1, where none may be present yet, after E2, where the expected outcome must be present, and one cycle later, where it must be gone. Consume is placed so that it is high exactly at the evaluating edge when a same-edge fetch, flush or idle combination is wanted.

// File: rtl/fetch_trace_pkg.sv
package fetch_trace_pkg;

    typedef struct packed {
        logic strobe_hi;   // reference strobe sampled high on last edge
        logic pin_low;     // fetch_n sampled low on last edge
        logic first;       // first window sample taken on last edge
        logic s0;          // credited first sample
        logic eval;        // second sample taken on last edge
        logic e0;          // first sample held for evaluation
        logic e1;          // second sample held for evaluation
        logic fetch;       // registered fetch outcome
        logic flush;       // registered flush outcome
    } sampler_state_t;

    localparam sampler_state_t SAMPLER_RESET = '{
        strobe_hi: 1'b1, pin_low: 1'b0, first: 1'b0, s0: 1'b0,
        eval: 1'b0, e0: 1'b0, e1: 1'b0, fetch: 1'b0, flush: 1'b0
    };

endpackage

// File: rtl/fetch_window_sampler.sv
module fetch_window_sampler
    import fetch_trace_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fetch_n,
    input  logic ref_strobe_n,
    input  logic two_clk_mode,
    output logic dec_fetch,
    output logic dec_flush,
    output logic fetch_pulse,
    output logic flush_pulse
);

    sampler_state_t st_d, st_q;
    logic           start_w;
    logic           credit0_w;

    always_comb begin
        st_d      = st_q;
        start_w   = st_q.strobe_hi && !ref_strobe_n;
        credit0_w = !fetch_n && (two_clk_mode || !st_q.pin_low);

        dec_flush = st_q.eval && st_q.e0 && st_q.e1;
        dec_fetch = st_q.eval && (st_q.e0 ^ st_q.e1);

        st_d.strobe_hi = ref_strobe_n;
        st_d.pin_low   = !fetch_n;
        st_d.first     = start_w;
        st_d.s0        = start_w ? credit0_w : 1'b0;
        st_d.eval      = st_q.first;
        st_d.e0        = st_q.first ? st_q.s0 : 1'b0;
        st_d.e1        = st_q.first ? !fetch_n : 1'b0;
        st_d.fetch     = dec_fetch;
        st_d.flush     = dec_flush;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SAMPLER_RESET;
        else     st_q <= st_d;
    end

    assign fetch_pulse = st_q.fetch;
    assign flush_pulse = st_q.flush;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(fetch_pulse && flush_pulse)); // R12
    AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (rst)
        (fetch_pulse || flush_pulse) |=> !(fetch_pulse || flush_pulse)); // R12
    AST_FLUSH_SECOND_LOW: assert property (@(posedge clk) disable iff (rst)
        flush_pulse |-> !$past(fetch_n, 2)); // R4

endmodule

// File: rtl/fetch_queue_counter.sv
module fetch_queue_counter #(
    parameter int QDEPTH = 3,
    localparam int CW = $clog2(QDEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch_i,
    input  logic          flush_i,
    input  logic          consume_i,
    output logic [CW-1:0] count_o
);

    localparam logic [CW-1:0] CMAX = CW'(QDEPTH);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (flush_i) begin
            cnt_d = ONE;
        end else if (fetch_i && !consume_i) begin
            if (cnt_q != CMAX) cnt_d = cnt_q + ONE;
        end else if (consume_i && !fetch_i) begin
            if (cnt_q != '0) cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    AST_FLUSH_ONE: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (cnt_q == ONE)); // R9
    AST_FETCH_INC: assert property (@(posedge clk) disable iff (rst)
        (fetch_i && !flush_i && !consume_i && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + ONE)); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (fetch_i && !flush_i && !consume_i && cnt_q == CMAX) |=> (cnt_q == CMAX)); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (consume_i && !fetch_i && !flush_i && cnt_q == '0) |=> (cnt_q == '0)); // R11
    AST_BALANCED: assert property (@(posedge clk) disable iff (rst)
        (consume_i && fetch_i && !flush_i) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/fetch_trace_decoder.sv
module fetch_trace_decoder #(
    parameter int QDEPTH = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fetch_n,
    input  logic                       as_n,
    input  logic                       ds_n,
    input  logic                       show_cycle,
    input  logic                       two_clk_mode,
    input  logic                       consume,
    output logic                       fetch_pulse,
    output logic                       flush_pulse,
    output logic [$clog2(QDEPTH+1)-1:0] occupancy
);

    logic ref_n;
    logic dec_fetch, dec_flush;

    assign ref_n = show_cycle ? ds_n : as_n;

    fetch_window_sampler u_sampler (
        .clk          (clk),
        .rst          (rst),
        .fetch_n      (fetch_n),
        .ref_strobe_n (ref_n),
        .two_clk_mode (two_clk_mode),
        .dec_fetch    (dec_fetch),
        .dec_flush    (dec_flush),
        .fetch_pulse  (fetch_pulse),
        .flush_pulse  (flush_pulse)
    );

    fetch_queue_counter #(.QDEPTH(QDEPTH)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .fetch_i   (dec_fetch),
        .flush_i   (dec_flush),
        .consume_i (consume),
        .count_o   (occupancy)
    );

    AST_FLUSH_SHOWS_ONE: assert property (@(posedge clk) disable iff (rst)
        flush_pulse |-> (occupancy == 1)); // R9

endmodule

// File: tb/fetch_trace_decoder_test.sv
module fetch_trace_decoder_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fetch_n = 1'b1, as_n = 1'b1, ds_n = 1'b1;
    logic show_cycle = 1'b0, two_clk_mode = 1'b1, consume = 1'b0;
    logic fetch_pulse, flush_pulse;
    logic [1:0] occupancy;

    int checks = 0;
    int errors = 0;
    int exp_occ = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fetch_trace_decoder uut (
        .clk(clk), .rst(rst), .fetch_n(fetch_n), .as_n(as_n), .ds_n(ds_n),
        .show_cycle(show_cycle), .two_clk_mode(two_clk_mode), .consume(consume),
        .fetch_pulse(fetch_pulse), .flush_pulse(flush_pulse), .occupancy(occupancy)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // set inputs now, then move to the next falling edge
    task automatic step(input logic strobe_low, input logic f, input logic c);
        if (show_cycle) begin ds_n = !strobe_low; as_n = 1'b1; end
        else            begin as_n = !strobe_low; ds_n = 1'b1; end
        fetch_n = f;
        consume = c;
        @(negedge clk);
    endtask

    function automatic int occ_next(input int occ, input bit ft, input bit fl, input bit c);
        if (fl) return 1;
        if (ft && !c) return (occ < 3) ? occ + 1 : 3;
        if (c && !ft) return (occ > 0) ? occ - 1 : 0;
        return occ;
    endfunction

    // one isolated bus cycle with samples f0, f1 and consume at the evaluating edge
    task automatic window(input logic f0, input logic f1, input logic c, input string tag);
        bit ft, fl;
        fl = !f0 && !f1;
        ft = (!f0) ^ (!f1);
        step(1'b1, f0, 1'b0);
        step(1'b0, f1, 1'b0);
        check({tag, " R2 early"}, fetch_pulse | flush_pulse, 0);
        step(1'b0, 1'b1, c);
        exp_occ = occ_next(exp_occ, ft, fl, c);
        check({tag, " R3 fetch"}, fetch_pulse, ft);
        check({tag, " R4 flush"}, flush_pulse, fl);
        check({tag, " R5/R9/R10/R11 occ"}, occupancy, exp_occ);
        step(1'b0, 1'b1, 1'b0);
        check({tag, " R2 one-cycle"}, fetch_pulse | flush_pulse, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset fetch", fetch_pulse, 0);
        check("R1 reset flush", flush_pulse, 0);
        check("R1 reset occ", occupancy, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {30'd0, occupancy} + fetch_pulse + flush_pulse, 0);

        // sweep: reference strobe x bus mode x sample pattern
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 2; m++) begin
                for (int p = 0; p < 4; p++) begin
                    show_cycle = s[0];
                    two_clk_mode = m[0];
                    window(p[1], p[0], 1'b0, $sformatf("sweep s%0d m%0d p%0d R6", s, m, p));
                end
            end
        end

        // saturation at 3 (R10)
        show_cycle = 1'b0; two_clk_mode = 1'b1;
        for (int k = 0; k < 4; k++) window(1'b0, 1'b1, 1'b0, "R10 saturate");
        // fetch with consume: unchanged (R11)
        window(1'b1, 1'b0, 1'b1, "R11 balanced");
        // flush with consume: forced to 1 (R9)
        window(1'b0, 1'b0, 1'b1, "R9 flush+consume");
        // drain with consume pulses, stop at 0 (R11)
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b1, 1'b1);
            exp_occ = occ_next(exp_occ, 1'b0, 1'b0, 1'b1);
            check("R11 drain", occupancy, exp_occ);
        end
        step(1'b0, 1'b1, 1'b0);

        // R6: non-reference strobe toggles with fetch low, nothing happens
        show_cycle = 1'b1;
        for (int k = 0; k < 3; k++) begin
            as_n = 1'b0; ds_n = 1'b1; fetch_n = 1'b0; @(negedge clk);
            as_n = 1'b1; @(negedge clk);
            check("R6 as_n ignored", fetch_pulse | flush_pulse, 0);
        end
        fetch_n = 1'b1; @(negedge clk); @(negedge clk);
        check("R6 as_n ignored pulse", fetch_pulse | flush_pulse, 0);
        check("R6 as_n ignored occ", occupancy, exp_occ);
        show_cycle = 1'b0;
        for (int k = 0; k < 3; k++) begin
            ds_n = 1'b0; as_n = 1'b1; fetch_n = 1'b0; @(negedge clk);
            ds_n = 1'b1; @(negedge clk);
            check("R6 ds_n ignored", fetch_pulse | flush_pulse, 0);
        end
        fetch_n = 1'b1; @(negedge clk); @(negedge clk);
        check("R6 ds_n ignored occ", occupancy, exp_occ);

        // back-to-back two-clock cycles with a three-edge low run
        for (int m = 1; m >= 0; m--) begin
            two_clk_mode = m[0];
            step(1'b1, 1'b0, 1'b0);   // E0 window A
            step(1'b0, 1'b0, 1'b0);   // E1 window A
            step(1'b1, 1'b0, 1'b0);   // E2 window B first sample, A evaluated
            exp_occ = occ_next(exp_occ, 1'b0, 1'b1, 1'b0);
            check("R7 flush first", flush_pulse, 1);
            check("R7 no fetch first", fetch_pulse, 0);
            step(1'b0, 1'b1, 1'b0);   // E3 window B second sample
            check("R12 spacing", fetch_pulse | flush_pulse, 0);
            step(1'b0, 1'b1, 1'b0);   // E4 window B evaluated
            if (m == 1) begin
                exp_occ = occ_next(exp_occ, 1'b1, 1'b0, 1'b0);
                check("R7 second fetch", fetch_pulse, 1);
            end else begin
                check("R8 continued low ignored", fetch_pulse, 0);
            end
            check("R7/R8 no flush", flush_pulse, 0);
            check("R7/R8 occ", occupancy, exp_occ);
            step(1'b0, 1'b1, 1'b0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule